// File: doc/BRIEF.md
# Paged Byte Address Counter

This block produces a running byte address for a memory array organised as 8192 pages. The page length is selectable between two settings: a long page of 528 bytes, which is not a power of two, and a short page of 512 bytes. A controller loads a start page and byte offset. It then pulses an increment strobe once for each byte transferred. The counter keeps the page number and the in-page offset as two separate fields.

When the offset passes the final byte of a page, the next increment lands on byte 0 of the following page. When it passes the final byte of page 8191, it lands on byte 0 of page 0. Neither step takes an extra cycle. Two flags mark the last byte of a page and the last byte of the array. An error flag pulses when a long-page load offset lies outside the page and has to be clamped.

Control is a two-state machine that guards the page-size setting:
- `ST_IDLE` means no increment was seen at the last edge.
- `ST_ADV` means an increment was seen at the last edge.
- The transition `ST_IDLE->ST_ADV` is taken on an edge where the increment strobe is high.
- The transition `ST_ADV->ST_IDLE` is taken on an edge where it is low.
- Both states hold on the same input.

The requested page size is copied into the active setting only in `ST_IDLE` and only at an edge where the strobe is low.

Top module: `pgaddr_counter`

## Requirements
- R1: While `rst_n` is low, the page and offset are 0, the error flag is 0, and the active page size is long (528 bytes).
- R2: At an edge with `load_i` high, the page becomes `load_page_i` and the offset becomes the loaded offset. Both are visible after that edge.
- R3: When `load_i` and `step_i` are high at the same edge, the load wins and no increment is applied.
- R4: At an edge with `step_i` high and `load_i` low, if the offset is below the final byte of the page, the offset rises by one and the page is unchanged.
- R5: In long mode (`long_mode_o`=1), an increment from offset 527 gives offset 0 and page+1 at that same edge.
- R6: In short mode (`long_mode_o`=0), an increment from offset 511 gives offset 0 and page+1 at that same edge. In this mode, a load takes only bits 8:0 of `load_off_i`, and bit 9 is ignored.
- R7: An increment from the final byte of page 8191 gives page 0, offset 0 at that same edge.
- R8: In long mode, a loaded offset of 528 or more is stored as 527, and `clamp_err_o` is high for exactly the one cycle after that load. A loaded offset of 527 or less raises no error.
- R9: `page_end_o` is 1 exactly while the offset equals the final byte of the page (527 long, 511 short).
- R10: `array_end_o` is 1 exactly while `page_end_o` is 1 and the page is 8191.
- R11: `long_mode_i` is copied to `long_mode_o` only at an edge where `step_i` is low and was also low at the previous edge. Otherwise `long_mode_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| long_mode_i | input | 1 | Requested page size: 1 = 528 bytes, 0 = 512 bytes |
| load_i | input | 1 | Load start address strobe |
| load_page_i | input | 13 | Start page |
| load_off_i | input | 10 | Start byte offset |
| step_i | input | 1 | Advance by one byte |
| page_o | output | 13 | Current page |
| offset_o | output | 10 | Current byte offset |
| page_end_o | output | 1 | Offset is the final byte of the page |
| array_end_o | output | 1 | Final byte of the final page |
| clamp_err_o | output | 1 | One-cycle pulse after a clamped load |
| long_mode_o | output | 1 | Active page size |

## Verification
Increments are run up to and across the page end in each size mode. This separates the 528-byte wrap point from the 512-byte one, and it shows whether the page advances on the same edge as the offset returns to zero. A run that starts from the final byte of page 8191 confirms the array wrap and the array-end flag, as distinct from an ordinary page change. Further patterns cover:
- loads at, and one past, the long-page boundary, which separate clamping from a plain load;
- a load coinciding with an increment, which shows the priority;
- size requests made during and just after increment bursts, which show when the active mode may change.

// File: rtl/pgaddr_pkg.sv
package pgaddr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ADV  = 1'b1
    } adv_state_t;
endpackage

// File: rtl/pgaddr_mode_ctl.sv
module pgaddr_mode_ctl
    import pgaddr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic mode_req,
    output logic mode_q
);
    adv_state_t state_q, state_d;
    logic       mode_we;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (step)  state_d = ST_ADV;
            ST_ADV:  if (!step) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_we = 1'b0;
        unique case (state_q)
            ST_IDLE: mode_we = !step;
            ST_ADV:  mode_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b1;
        else if (mode_we) mode_q <= mode_req;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step || state_q == ST_ADV) |=> $stable(mode_q)); // R11
endmodule

// File: rtl/pgaddr_offset.sv
module pgaddr_offset #(
    parameter int LONG_LEN  = 528,
    parameter int SHORT_LEN = 512,
    parameter int OFF_W     = $clog2(LONG_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_long,
    input  logic             load,
    input  logic [OFF_W-1:0] load_off,
    input  logic             step,
    output logic [OFF_W-1:0] off_q,
    output logic             at_last,
    output logic             wrap,
    output logic             err_q
);
    localparam int SHORT_W = $clog2(SHORT_LEN);
    localparam logic [OFF_W-1:0] LONG_LAST  = OFF_W'(LONG_LEN - 1);
    localparam logic [OFF_W-1:0] SHORT_LAST = OFF_W'(SHORT_LEN - 1);

    logic [OFF_W-1:0] last_off;
    logic [OFF_W-1:0] load_eff;
    logic             load_bad;

    always_comb begin
        last_off = mode_long ? LONG_LAST : SHORT_LAST;
        load_bad = mode_long && (load_off > LONG_LAST);
        if (mode_long)
            load_eff = load_bad ? LONG_LAST : load_off;
        else
            load_eff = OFF_W'(load_off[SHORT_W-1:0]);
        at_last = (off_q == last_off);
        wrap    = step && !load && (off_q >= last_off);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= load && load_bad;
            if (load)      off_q <= load_eff;
            else if (wrap) off_q <= '0;
            else if (step) off_q <= off_q + OFF_W'(1);
        end
    end

    AST_OFF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && off_q == last_off) |=> (off_q == '0)); // R5
    AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode_long && load_off >= OFF_W'(LONG_LEN)) |=> (err_q && off_q == LONG_LAST)); // R8
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(load)); // R8
endmodule

// File: rtl/pgaddr_page.sv
module pgaddr_page #(
    parameter int PAGE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              adv,
    output logic [PAGE_W-1:0] page_q,
    output logic              at_top
);
    localparam logic [PAGE_W-1:0] TOP = {PAGE_W{1'b1}};

    always_comb at_top = (page_q == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)     page_q <= '0;
        else if (load)  page_q <= load_page;
        else if (adv)   page_q <= at_top ? '0 : page_q + PAGE_W'(1);
    end

    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && page_q == TOP) |=> (page_q == '0)); // R7
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(page_q)); // R4
endmodule

// File: rtl/pgaddr_counter.sv
module pgaddr_counter #(
    parameter int PAGE_W    = 13,
    parameter int LONG_LEN  = 528,
    parameter int SHORT_LEN = 512,
    parameter int OFF_W     = $clog2(LONG_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_mode_i,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] load_page_i,
    input  logic [OFF_W-1:0]  load_off_i,
    input  logic              step_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic              page_end_o,
    output logic              array_end_o,
    output logic              clamp_err_o,
    output logic              long_mode_o
);
    logic mode_q;
    logic wrap;
    logic at_last;
    logic at_top;

    pgaddr_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_i),
        .mode_req (long_mode_i),
        .mode_q   (mode_q)
    );

    pgaddr_offset #(
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN),
        .OFF_W     (OFF_W)
    ) u_off (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_long (mode_q),
        .load      (load_i),
        .load_off  (load_off_i),
        .step      (step_i),
        .off_q     (offset_o),
        .at_last   (at_last),
        .wrap      (wrap),
        .err_q     (clamp_err_o)
    );

    pgaddr_page #(
        .PAGE_W (PAGE_W)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_i),
        .load_page (load_page_i),
        .adv       (wrap),
        .page_q    (page_o),
        .at_top    (at_top)
    );

    always_comb begin
        long_mode_o = mode_q;
        page_end_o  = at_last;
        array_end_o = at_last && at_top;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && step_i) |=> (page_o == $past(load_page_i))); // R3
    AST_WRAP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && page_end_o && !array_end_o) |=> (offset_o == '0 && page_o == $past(page_o) + PAGE_W'(1))); // R5
endmodule

// File: tb/pgaddr_counter_test.sv
module pgaddr_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_mode_i = 1'b1;
    logic        load_i = 1'b0;
    logic [12:0] load_page_i = '0;
    logic [9:0]  load_off_i = '0;
    logic        step_i = 1'b0;
    logic [12:0] page_o;
    logic [9:0]  offset_o;
    logic        page_end_o, array_end_o, clamp_err_o, long_mode_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pgaddr_counter uut (
        .clk(clk), .rst_n(rst_n), .long_mode_i(long_mode_i), .load_i(load_i),
        .load_page_i(load_page_i), .load_off_i(load_off_i), .step_i(step_i),
        .page_o(page_o), .offset_o(offset_o), .page_end_o(page_end_o),
        .array_end_o(array_end_o), .clamp_err_o(clamp_err_o), .long_mode_o(long_mode_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        long_mode_i = m; step_i = 0; load_i = 0;
        tick(); tick();
    endtask

    task automatic do_load(input int pg, input int off);
        load_i = 1; load_page_i = 13'(pg); load_off_i = 10'(off);
        tick();
        load_i = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; tick(); tick();
        chk("R1 page", page_o, 0);
        chk("R1 offset", offset_o, 0);
        chk("R1 err", clamp_err_o, 0);
        chk("R1 mode", long_mode_o, 1);
        rst_n = 1; tick();
    endtask

    task automatic t_load_step();
        set_mode(1);
        do_load(300, 41);
        chk("R2 page", page_o, 300);
        chk("R2 offset", offset_o, 41);
        step_i = 1; tick(); tick(); step_i = 0;
        chk("R4 offset", offset_o, 43);
        chk("R4 page", page_o, 300);
        tick();
        chk("R4 idle hold", offset_o, 43);
    endtask

    task automatic t_priority();
        load_i = 1; step_i = 1; load_page_i = 100; load_off_i = 20;
        tick();
        load_i = 0; step_i = 0;
        chk("R3 offset", offset_o, 20);
        chk("R3 page", page_o, 100);
    endtask

    task automatic t_long_wrap();
        set_mode(1);
        do_load(5, 526);
        chk("R9 not end", page_end_o, 0);
        step_i = 1; tick();
        chk("R9 end 527", page_end_o, 1);
        chk("R5 at 527", offset_o, 527);
        tick(); step_i = 0;
        chk("R5 offset", offset_o, 0);
        chk("R5 page", page_o, 6);
        chk("R9 cleared", page_end_o, 0);
    endtask

    task automatic t_short_wrap();
        set_mode(0);
        chk("R11 short", long_mode_o, 0);
        do_load(7, 510);
        step_i = 1; tick();
        chk("R9 end 511", page_end_o, 1);
        tick(); step_i = 0;
        chk("R6 offset", offset_o, 0);
        chk("R6 page", page_o, 8);
        do_load(9, 10'h205);
        chk("R6 bit9 ignored", offset_o, 5);
        chk("R8 no err short", clamp_err_o, 0);
    endtask

    task automatic t_array_wrap();
        set_mode(1);
        do_load(8191, 527);
        chk("R10 array end", array_end_o, 1);
        step_i = 1; tick(); step_i = 0;
        chk("R7 page", page_o, 0);
        chk("R7 offset", offset_o, 0);
        chk("R10 cleared", array_end_o, 0);
        do_load(8190, 527);
        chk("R10 not last page", array_end_o, 0);
        chk("R9 page end", page_end_o, 1);
    endtask

    task automatic t_clamp();
        set_mode(1);
        do_load(3, 600);
        chk("R8 clamped", offset_o, 527);
        chk("R8 err pulse", clamp_err_o, 1);
        tick();
        chk("R8 err one cycle", clamp_err_o, 0);
        do_load(3, 528);
        chk("R8 528 clamped", offset_o, 527);
        chk("R8 528 err", clamp_err_o, 1);
        do_load(3, 527);
        chk("R8 527 ok", clamp_err_o, 0);
        chk("R8 527 value", offset_o, 527);
    endtask

    task automatic t_mode_hold();
        set_mode(1);
        do_load(0, 0);
        step_i = 1; long_mode_i = 0; tick();
        chk("R11 hold in step", long_mode_o, 1);
        step_i = 0; tick();
        chk("R11 hold after step", long_mode_o, 1);
        tick();
        chk("R11 applied", long_mode_o, 0);
        set_mode(1);
        chk("R11 back long", long_mode_o, 1);
    endtask

    initial begin
        tick();
        t_reset();
        t_load_step();
        t_priority();
        t_long_wrap();
        t_short_wrap();
        t_array_wrap();
        t_clamp();
        t_mode_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule